// File: doc/BRIEF.md
# Error-Correcting End-of-Column Hit Buffer

This block sits at the foot of one double column of a pixel readout matrix. The cells of that double column share one data bus. Each cell holding an unread hit raises its own pending line. The block picks one cell per clock and reads that cell's two timestamps off the shared bus. It then stores the complete hit word in a 32-entry first-in first-out buffer. The downstream transmission multiplexer drains the buffer with a valid/ready handshake. That multiplexer gathers many double columns onto a few serial links.

Every stored word is a 32-bit record made of an 8-bit cell address, a 12-bit rising-edge time and a 12-bit falling-edge time. A single-error-correcting, double-error-detecting (SEC-DED) Hamming code protects it: six check bits plus one overall parity bit, 39 bits in total. The code is generated when a word is written and checked when it is read. A single upset in storage is repaired on the way out and counted. A double upset is flagged, and the word is still delivered. The read and write pointers are held as three copies with a majority vote, so one flipped pointer bit cannot reorder or lose entries. A test-only upset input flips chosen bits of the codeword as it is stored, to emulate radiation damage.

Top module: `eoc_secded_fifo`

## Requirements
- R1: After synchronous reset the buffer is empty, `out_valid` and `grant_valid` are low while no cell is pending, and `sec_count` is zero.
- R2: When at least one `cell_pending` bit is set and the buffer is not full, `grant_valid` is high and `grant_addr` is the lowest set index. In that cycle the word `{grant_addr, bus_le, bus_te}` is stored.
- R3: While the buffer holds 32 words, `grant_valid` stays low, so no cell is read and pending hits remain in their cells. Granting resumes once a word leaves.
- R4: Words leave in the order they were stored. `out_addr`, `out_le` and `out_te` reproduce the stored address, rising-edge time and falling-edge time.
- R5: A flip of any one of the 39 stored codeword bits is corrected on read: the data fields are exact and `out_sec` is high.
- R6: A flip of two stored codeword bits sets `out_ded`, keeps `out_sec` low, and the word is still presented with `out_valid` high.
- R7: `sec_count` increases by one for each word that is removed (`out_valid` and `out_ready` both high) with `out_sec` high. It does not change otherwise, and it saturates at its maximum (255).
- R8: With no pending cell, `grant_valid` stays low and nothing is written.
- R9: `out_valid` is high exactly when the buffer is not empty. A word is removed only in a cycle where `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_pending | input | 256 | One pending-hit line per cell of the double column |
| grant_valid | output | 1 | A cell is selected and read this cycle |
| grant_addr | output | 8 | Address of the selected cell; it drives the shared bus |
| bus_le | input | 12 | Rising-edge time driven by the selected cell |
| bus_te | input | 12 | Falling-edge time driven by the selected cell |
| seu_flip | input | 39 | Test upset mask XORed into the codeword being stored |
| out_valid | output | 1 | A word is available at the output |
| out_ready | input | 1 | The downstream multiplexer accepts the word |
| out_addr | output | 8 | Cell address of the head word |
| out_le | output | 12 | Rising-edge time of the head word |
| out_te | output | 12 | Falling-edge time of the head word |
| out_sec | output | 1 | The head word had a single-bit error that has been corrected |
| out_ded | output | 1 | The head word has an uncorrectable double-bit error |
| sec_count | output | 8 | Saturating count of corrected words removed |

## Verification
Storage upsets cannot happen in normal operation, and they are the hardest condition to create. The stimulus reaches them by loading a single cell and holding a one-hot or two-hot upset mask during exactly the clock edge on which that cell's word is stored. It walks the single flip across all 39 codeword positions, parity bits included, and then runs enough corrected reads to drive the counter into saturation. A full buffer with hits still waiting is the other hard case. It is reached by raising 40 pending lines with the consumer stalled.

// File: rtl/eoc_fifo_pkg.sv
package eoc_fifo_pkg;

    localparam int ADDR_W = 8;
    localparam int TIME_W = 12;
    localparam int DATA_W = ADDR_W + 2 * TIME_W;
    localparam int CHK_W  = 6;                    // 2**CHK_W >= DATA_W + CHK_W + 1
    localparam int CODE_W = DATA_W + CHK_W + 1;   // bit 0 holds overall parity
    localparam int NCELL  = 1 << ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [TIME_W-1:0] le;
        logic [TIME_W-1:0] te;
    } hit_word_t;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        hit_word_t word;
        logic      sec;
        logic      ded;
    } dec_t;

    function automatic logic is_pow2(input int i);
        return (i & (i - 1)) == 0;
    endfunction

    // Positional Hamming layout: check bits at powers of two, data elsewhere.
    function automatic code_t secded_encode(input hit_word_t w);
        code_t             c;
        logic [DATA_W-1:0] d;
        int                k;
        logic              par;
        d = w;
        c = '0;
        k = 0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!is_pow2(i)) begin
                c[i] = d[k];
                k++;
            end
        end
        for (int b = 0; b < CHK_W; b++) begin
            par = 1'b0;
            for (int i = 1; i < CODE_W; i++) begin
                if (((i >> b) & 1) == 1 && i != (1 << b)) par ^= c[i];
            end
            c[1 << b] = par;
        end
        c[0] = ^c[CODE_W-1:1];
        return c;
    endfunction

    function automatic dec_t secded_decode(input code_t c);
        dec_t              r;
        code_t             f;
        logic [CHK_W-1:0]  syn;
        logic [DATA_W-1:0] d;
        int                k;
        syn = '0;
        for (int i = 1; i < CODE_W; i++) begin
            if (c[i]) syn ^= CHK_W'(i);
        end
        f     = c;
        r.sec = 1'b0;
        r.ded = 1'b0;
        if (^c) begin
            if (int'(syn) < CODE_W) begin
                r.sec = 1'b1;
                if (syn != '0) f[syn] = ~f[syn];
            end else begin
                r.ded = 1'b1;
            end
        end else if (syn != '0) begin
            r.ded = 1'b1;
        end
        d = '0;
        k = 0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!is_pow2(i)) begin
                d[k] = f[i];
                k++;
            end
        end
        r.word = d;
        return r;
    endfunction

endpackage

// File: rtl/eoc_prio_arb.sv
module eoc_prio_arb #(
    parameter int N  = 256,
    parameter int AW = 8
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [AW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/eoc_tmr_store.sv
module eoc_tmr_store #(
    parameter int DEPTH = 32,
    parameter int W     = 39
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [$clog2(DEPTH):0] occ,
    output logic          full,
    output logic          empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int NCOPY = 3;

    logic [PW:0]  wp_q [NCOPY];
    logic [PW:0]  rp_q [NCOPY];
    logic [PW:0]  wp_v, rp_v;
    logic [W-1:0] mem  [DEPTH];

    // Majority vote across the three pointer copies
    assign wp_v = (wp_q[0] & wp_q[1]) | (wp_q[0] & wp_q[2]) | (wp_q[1] & wp_q[2]);
    assign rp_v = (rp_q[0] & rp_q[1]) | (rp_q[0] & rp_q[2]) | (rp_q[1] & rp_q[2]);

    // Every copy is rewritten from the voted value each cycle (scrubbing)
    always_ff @(posedge clk) begin
        for (int g = 0; g < NCOPY; g++) begin
            if (rst) begin
                wp_q[g] <= '0;
                rp_q[g] <= '0;
            end else begin
                wp_q[g] <= push ? wp_v + 1'b1 : wp_v;
                rp_q[g] <= pop  ? rp_v + 1'b1 : rp_v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp_v[PW-1:0]] <= wdata;
    end

    assign rdata = mem[rp_v[PW-1:0]];
    assign occ   = wp_v - rp_v;
    assign full  = (occ == (PW+1)'(DEPTH));
    assign empty = (occ == '0);
endmodule

// File: rtl/eoc_secded_fifo.sv
module eoc_secded_fifo
    import eoc_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCELL-1:0]  cell_pending,
    output logic              grant_valid,
    output logic [ADDR_W-1:0] grant_addr,
    input  logic [TIME_W-1:0] bus_le,
    input  logic [TIME_W-1:0] bus_te,
    input  logic [CODE_W-1:0] seu_flip,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TIME_W-1:0] out_le,
    output logic [TIME_W-1:0] out_te,
    output logic              out_sec,
    output logic              out_ded,
    output logic [CNT_W-1:0]  sec_count
);
    localparam int PW = $clog2(DEPTH);

    logic              any_req;
    logic [ADDR_W-1:0] pick;
    logic              full, empty, pop;
    logic [PW:0]       occ;
    hit_word_t         in_word;
    code_t             wcode, rcode;
    dec_t              dec;
    logic [CNT_W-1:0]  cnt_q;

    eoc_prio_arb #(.N(NCELL), .AW(ADDR_W)) u_arb (
        .req (cell_pending),
        .any (any_req),
        .idx (pick)
    );

    assign grant_valid = any_req && !full;
    assign grant_addr  = pick;

    always_comb begin
        in_word.addr = pick;
        in_word.le   = bus_le;
        in_word.te   = bus_te;
        wcode        = secded_encode(in_word) ^ seu_flip;
    end

    eoc_tmr_store #(.DEPTH(DEPTH), .W(CODE_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (grant_valid),
        .wdata (wcode),
        .pop   (pop),
        .rdata (rcode),
        .occ   (occ),
        .full  (full),
        .empty (empty)
    );

    assign out_valid = !empty;
    assign pop       = out_valid && out_ready;
    assign dec       = secded_decode(rcode);
    assign out_addr  = dec.word.addr;
    assign out_le    = dec.word.le;
    assign out_te    = dec.word.te;
    assign out_sec   = dec.sec;
    assign out_ded   = dec.ded;

    always_ff @(posedge clk) begin
        if (rst)                                 cnt_q <= '0;
        else if (pop && dec.sec && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
    end
    assign sec_count = cnt_q;
endmodule

// File: rtl/eoc_fifo_checker.sv
module eoc_fifo_checker #(
    parameter int NCELL = 256,
    parameter int AW    = 8,
    parameter int DEPTH = 32,
    parameter int CNT_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCELL-1:0]       cell_pending,
    input logic                   grant_valid,
    input logic [AW-1:0]          grant_addr,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic                   out_sec,
    input logic                   out_ded,
    input logic [CNT_W-1:0]       sec_count,
    input logic [$clog2(DEPTH):0] occ
);
    localparam int PW = $clog2(DEPTH);
    logic popping;
    assign popping = out_valid && out_ready;

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (occ == '0 && sec_count == '0));

    p_lowest_first_r2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (cell_pending[grant_addr] &&
                         ((cell_pending & ~({NCELL{1'b1}} << grant_addr)) == '0)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        occ <= (PW+1)'(DEPTH));

    p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (occ == (PW+1)'(DEPTH) && !popping) |=> occ == (PW+1)'(DEPTH));

    p_occ_step_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> occ == $past(occ) + (PW+1)'($past(grant_valid)) - (PW+1)'($past(popping)));

    p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(out_sec && out_ded));

    p_cnt_inc_r7: assert property (@(posedge clk) disable iff (rst)
        (popping && out_sec && sec_count != '1) |=> sec_count == $past(sec_count) + 1'b1);

    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(popping && out_sec) |=> $stable(sec_count));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (cell_pending == '0) |-> !grant_valid);

    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid == (occ != '0));
endmodule

bind eoc_secded_fifo eoc_fifo_checker #(
    .NCELL (eoc_fifo_pkg::NCELL),
    .AW    (eoc_fifo_pkg::ADDR_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cell_pending (cell_pending),
    .grant_valid  (grant_valid),
    .grant_addr   (grant_addr),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_sec      (out_sec),
    .out_ded      (out_ded),
    .sec_count    (sec_count),
    .occ          (occ)
);

// File: tb/test_eoc_secded_fifo.sv
module test_eoc_secded_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 256;
    localparam int CW  = 39;

    logic           clk = 1'b0;
    logic           rst;
    logic [NC-1:0]  pending;
    logic [NC-1:0]  load_mask;
    logic           grant_valid;
    logic [7:0]     grant_addr;
    logic [11:0]    bus_le, bus_te;
    logic [CW-1:0]  seu_flip;
    logic           out_valid, out_ready;
    logic [7:0]     out_addr;
    logic [11:0]    out_le, out_te;
    logic           out_sec, out_ded;
    logic [7:0]     sec_count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eoc_secded_fifo i_eoc_secded_fifo (
        .clk (clk), .rst (rst), .cell_pending (pending),
        .grant_valid (grant_valid), .grant_addr (grant_addr),
        .bus_le (bus_le), .bus_te (bus_te), .seu_flip (seu_flip),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_addr (out_addr), .out_le (out_le), .out_te (out_te),
        .out_sec (out_sec), .out_ded (out_ded), .sec_count (sec_count)
    );

    function automatic logic [11:0] le_of(input logic [7:0] a);
        return {a[3:0], ~a};
    endfunction
    function automatic logic [11:0] te_of(input logic [7:0] a);
        return 12'(a * 13 + 7);
    endfunction

    // Cell model: a granted cell drops its pending line at the clock edge
    always_comb begin
        bus_le = le_of(grant_addr);
        bus_te = te_of(grant_addr);
    end
    always @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= (pending & ~(grant_valid ? (NC'(1) << grant_addr) : '0)) | load_mask;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic load_cells(input logic [NC-1:0] m);
        @(negedge clk);
        load_mask = m;
        @(negedge clk);
        load_mask = '0;
    endtask

    // Wait for a head word, check it, then remove it
    task automatic pop_expect(input string req, input logic [7:0] a,
                              input logic sec_e, input logic ded_e, input logic data_chk);
        int w = 0;
        while (!out_valid && w < 50) begin
            @(negedge clk);
            w++;
        end
        chk({req, " valid"}, out_valid, 1);
        if (data_chk) begin
            chk({req, " addr"}, out_addr, a);
            chk({req, " le"}, out_le, le_of(a));
            chk({req, " te"}, out_te, te_of(a));
        end
        chk({req, " sec"}, out_sec, sec_e);
        chk({req, " ded"}, out_ded, ded_e);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 grant_valid", grant_valid, 0);
        chk("R1 sec_count", sec_count, 0);
    endtask

    task automatic t_idle;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8 idle grant", grant_valid, 0);
            chk("R9 idle valid", out_valid, 0);
        end
    endtask

    task automatic t_priority;
        logic [NC-1:0] m = '0;
        m[200] = 1'b1; m[5] = 1'b1; m[77] = 1'b1; m[130] = 1'b1;
        @(negedge clk);
        load_mask = m;
        @(negedge clk);
        load_mask = '0;
        chk("R2 first grant", grant_valid, 1);
        chk("R2 lowest addr", grant_addr, 5);
        @(negedge clk);
        chk("R2 second addr", grant_addr, 77);
        repeat (4) @(negedge clk);
        chk("R9 held without ready", out_valid, 1);
        chk("R2 all granted", pending == '0, 1);
        pop_expect("R4 order", 5, 0, 0, 1);
        pop_expect("R4 order", 77, 0, 0, 1);
        pop_expect("R4 order", 130, 0, 0, 1);
        pop_expect("R4 order", 200, 0, 0, 1);
        chk("R9 empty after drain", out_valid, 0);
    endtask

    task automatic t_full;
        logic [NC-1:0] m = '0;
        for (int i = 0; i < 40; i++) m[i] = 1'b1;
        load_cells(m);
        repeat (45) @(negedge clk);
        chk("R3 no grant when full", grant_valid, 0);
        chk("R3 hits kept in cells", $countones(pending), 8);
        chk("R3 lowest kept pending", pending[32], 1);
        for (int i = 0; i < 40; i++) pop_expect("R3 R4 drain", 8'(i), 0, 0, 1);
        chk("R3 all cells read", pending == '0, 1);
    endtask

    task automatic inject(input logic [CW-1:0] mask, input logic [7:0] a);
        logic [NC-1:0] m = '0;
        m[a] = 1'b1;
        @(negedge clk);
        load_mask = m;
        seu_flip  = mask;
        @(negedge clk);
        load_mask = '0;
        @(negedge clk);
        seu_flip  = '0;
    endtask

    task automatic t_single;
        for (int p = 0; p < CW; p++) begin
            inject(CW'(1) << p, 8'(p * 6));
            pop_expect("R5 single flip", 8'(p * 6), 1, 0, 1);
            chk("R7 count step", sec_count, p + 1);
        end
    endtask

    task automatic t_double;
        inject((CW'(1) << 1) | (CW'(1) << 2), 8'd11);
        pop_expect("R6 double flip", 8'd11, 0, 1, 0);
        inject((CW'(1) << 0) | (CW'(1) << 38), 8'd99);
        pop_expect("R6 double flip", 8'd99, 0, 1, 0);
        inject((CW'(1) << 10) | (CW'(1) << 20), 8'd250);
        pop_expect("R6 double flip", 8'd250, 0, 1, 0);
        chk("R7 no count on double", sec_count, 39);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 219; i++) begin
            inject(CW'(1) << (i % CW), 8'(i));
            pop_expect("R7 sat fill", 8'(i), 1, 0, 1);
        end
        chk("R7 saturated", sec_count, 255);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst       = 1'b1;
        load_mask = '0;
        seu_flip  = '0;
        out_ready = 1'b0;
        t_reset();
        t_idle();
        t_priority();
        t_full();
        t_single();
        t_double();
        t_saturate();
        summary();
    end
endmodule